// File: doc/BRIEF.md
# Hierarchical Ping-Pong Active-Vertex Set

This block keeps the set of graph vertices that will be active in the next iteration while it streams out the set for the current one. Storage is split into two banks. At any time one bank takes inserts and the other is drained. A swap request exchanges their roles at an iteration boundary. Inserting a vertex sets one bit in every level of a three-level summary: the top level has one bit per coarse group, the middle level one bit per medium group, and the bottom level one bit per vertex. All three writes happen in the same cycle.

Extraction begins by reading the small top word. Each level turns the set bits of the word it holds into child indices, lowest first, and passes them through a short FIFO to the level below. Only marked groups are ever read, so empty regions of the ID space cost no cycles. Vertex IDs leave on a valid/ready port in strictly ascending order. Each word is wiped from the drained bank when it is read, so the bank is empty by the time it takes inserts again. A one-cycle end-of-list pulse closes every iteration.

Top module: `hier_active_set`

## Requirements
- R1: After reset both banks are empty, `out_valid` and `out_last` are low, and the first swap yields an end-of-list pulse with no IDs.
- R2: After an accepted swap, every distinct vertex inserted since the previous accepted swap appears on `out_vid` exactly once, in strictly increasing order. Repeated inserts of one ID merge into a single entry.
- R3: An insert in the same cycle as an accepted swap belongs to the list being started. An insert in the following cycle belongs to the next list.
- R4: Inserts made while a list is being extracted never appear in that list. They appear in the list started by the next swap.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vid` does not change.
- R6: `out_last` is a single-cycle pulse one or more cycles after the final ID handshake, with `out_valid` low in that cycle. An empty list gives the pulse with no IDs.
- R7: A swap requested while a list is still being extracted is remembered and takes effect at the end of the `out_last` cycle. No ID is offered between the end pulse and a swap being accepted.
- R8: A drained bank holds no stale marks. When it is read again, only IDs inserted since its last drain appear.
- R9: The whole ID range 0 to 2^(3·GRP_W)−1 (0 to 4095 by default) is supported. The top level is indexed by bits [11:8], the middle level by [7:4] and the bottom level by [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert strobe; marks `ins_vid` in the write bank |
| ins_vid | input | 12 | Vertex ID to mark active for the next iteration |
| swap_req | input | 1 | Single-cycle request to exchange banks and start extraction |
| out_valid | output | 1 | `out_vid` holds an active vertex ID |
| out_vid | output | 12 | Extracted vertex ID, ascending within one list |
| out_ready | input | 1 | Consumer accepts `out_vid` when high together with `out_valid` |
| out_last | output | 1 | One-cycle pulse after the final ID of a list |

## Verification
The hardest situation to reach from the ports is a swap request arriving while a long extraction is still running, with fresh inserts landing in the other bank at the same time. To get there, the bench starts a list of several dozen IDs, holds `out_ready` low for three cycles in four so the drain lasts long, and meanwhile issues inserts and a second swap. The pending swap must then start the second list right after the pulse. Same-cycle insert-and-swap, back-to-back empty swaps that re-read a drained bank, and randomly stalled consumers complete the picture.

// File: rtl/has_pkg.sv
package has_pkg;

    localparam int unsigned DEF_GRP_W  = 4;
    localparam int unsigned DEF_LEVELS = 3;
    localparam int unsigned DEF_FIFO_D = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e st;
        logic       wbank;
        logic       pend;
        logic       last;
    } ctl_t;

    // Right shift of a vertex ID that yields the word address at a level.
    function automatic int unsigned word_shift(int unsigned lvl, int unsigned levels,
                                               int unsigned grp_w);
        return grp_w * (levels - lvl);
    endfunction

    // Right shift of a vertex ID that yields the bit position at a level.
    function automatic int unsigned bit_shift(int unsigned lvl, int unsigned levels,
                                              int unsigned grp_w);
        return grp_w * (levels - 1 - lvl);
    endfunction

endpackage

// File: rtl/has_fifo.sv
module has_fifo #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned SLOTS = 1 << AW;

    logic [W-1:0] store [SLOTS];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign full  = (cnt == (AW+1)'(SLOTS));
    assign empty = (cnt == '0);
    assign dout  = store[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                store[wp] <= din;
                wp        <= wp + 1'b1;
            end
            if (pop) rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R2

endmodule

// File: rtl/has_level_bits.sv
module has_level_bits #(
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned ADDR_W0 = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wbank,
    input  logic                     ins_en,
    input  logic [((ADDR_W0>0)?ADDR_W0:1)-1:0] ins_addr,
    input  logic [GRP_W-1:0]         ins_bit,
    input  logic                     clr_en,
    input  logic [((ADDR_W0>0)?ADDR_W0:1)-1:0] rd_addr,
    output logic [(1<<GRP_W)-1:0]    rd_word
);
    localparam int unsigned FAN   = 1 << GRP_W;
    localparam int unsigned AW    = (ADDR_W0 > 0) ? ADDR_W0 : 1;
    localparam int unsigned WORDS = 1 << AW;

    logic [FAN-1:0] mem [2][WORDS];

    assign rd_word = mem[~wbank][rd_addr];

    // Inserts only touch the write bank; clears only touch the read bank.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int w = 0; w < int'(WORDS); w++)
                    mem[b][w] <= '0;
        end else begin
            if (ins_en) mem[wbank][ins_addr][ins_bit] <= 1'b1;
            if (clr_en) mem[~wbank][rd_addr] <= '0;
        end
    end

endmodule

// File: rtl/has_scan.sv
module has_scan #(
    parameter int unsigned GRP_W      = 4,
    parameter int unsigned VID_W      = 12,
    parameter bit          EXPECT_ONE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  src_valid,
    input  logic [VID_W-1:0]      src_grp,
    output logic                  src_pop,
    input  logic [(1<<GRP_W)-1:0] rd_word,
    output logic                  dst_valid,
    output logic [VID_W-1:0]      dst_idx,
    input  logic                  dst_ready
);
    localparam int unsigned FAN = 1 << GRP_W;

    logic [FAN-1:0]   word;
    logic [VID_W-1:0] grp;
    logic [GRP_W-1:0] low;

    always_comb begin
        low = '0;
        for (int i = FAN - 1; i >= 0; i--)
            if (word[i]) low = GRP_W'(i);
    end

    assign dst_valid = (word != '0);
    assign dst_idx   = VID_W'({grp, low});
    assign src_pop   = src_valid && (word == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            grp  <= '0;
        end else if (src_pop) begin
            word <= rd_word;
            grp  <= src_grp;
        end else if (dst_valid && dst_ready) begin
            word <= word & ~(FAN'(1) << low);
        end
    end

    generate
        if (EXPECT_ONE) begin : g_chk
            // A group marked above must have at least one mark below it.
            AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
                src_pop |-> (rd_word != '0));  // R8
        end
    endgenerate

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_idx)));  // R5

endmodule

// File: rtl/hier_active_set.sv
module hier_active_set
    import has_pkg::*;
#(
    parameter int unsigned GRP_W   = DEF_GRP_W,
    parameter int unsigned LEVELS  = DEF_LEVELS,
    parameter int unsigned FIFO_D  = DEF_FIFO_D,
    localparam int unsigned VID_W  = GRP_W * LEVELS,
    localparam int unsigned FAN    = 1 << GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic [VID_W-1:0] ins_vid,
    input  logic             swap_req,
    output logic             out_valid,
    output logic [VID_W-1:0] out_vid,
    input  logic             out_ready,
    output logic             out_last
);
    ctl_t ctl_q, ctl_d;

    logic             src_valid [LEVELS];
    logic [VID_W-1:0] src_grp   [LEVELS];
    logic             src_pop   [LEVELS];
    logic             dst_valid [LEVELS];
    logic [VID_W-1:0] dst_idx   [LEVELS];
    logic             dst_ready [LEVELS];
    logic [FAN-1:0]   rd_word   [LEVELS];
    logic             lvl_empty [LEVELS];

    genvar L;
    generate
        for (L = 0; L < LEVELS; L++) begin : g_lvl
            localparam int unsigned AW0 = GRP_W * L;
            localparam int unsigned AW  = (AW0 > 0) ? AW0 : 1;
            localparam int unsigned SHW = word_shift(L, LEVELS, GRP_W);
            localparam int unsigned SHB = bit_shift(L, LEVELS, GRP_W);

            logic [AW-1:0]    ins_addr;
            logic [GRP_W-1:0] ins_bit;
            logic [AW-1:0]    rd_addr;

            assign ins_addr = (AW0 > 0) ? AW'(ins_vid >> SHW) : '0;
            assign ins_bit  = GRP_W'(ins_vid >> SHB);
            assign rd_addr  = (AW0 > 0) ? AW'(src_grp[L]) : '0;

            has_level_bits #(.GRP_W(GRP_W), .ADDR_W0(AW0)) u_bits (
                .clk      (clk),
                .rst      (rst),
                .wbank    (ctl_q.wbank),
                .ins_en   (ins_valid),
                .ins_addr (ins_addr),
                .ins_bit  (ins_bit),
                .clr_en   (src_pop[L]),
                .rd_addr  (rd_addr),
                .rd_word  (rd_word[L])
            );

            has_scan #(.GRP_W(GRP_W), .VID_W(VID_W), .EXPECT_ONE(L > 0)) u_scan (
                .clk       (clk),
                .rst       (rst),
                .src_valid (src_valid[L]),
                .src_grp   (src_grp[L]),
                .src_pop   (src_pop[L]),
                .rd_word   (rd_word[L]),
                .dst_valid (dst_valid[L]),
                .dst_idx   (dst_idx[L]),
                .dst_ready (dst_ready[L])
            );

            if (L == 0) begin : g_head
                assign src_valid[L] = (ctl_q.st == ST_LOAD);
                assign src_grp[L]   = '0;
                assign lvl_empty[L] = 1'b1;
            end else begin : g_link
                logic f_full, f_empty;
                has_fifo #(.W(VID_W), .DEPTH(FIFO_D)) u_fifo (
                    .clk   (clk),
                    .rst   (rst),
                    .push  (dst_valid[L-1] && !f_full),
                    .din   (dst_idx[L-1]),
                    .pop   (src_pop[L]),
                    .dout  (src_grp[L]),
                    .full  (f_full),
                    .empty (f_empty)
                );
                assign dst_ready[L-1] = !f_full;
                assign src_valid[L]   = !f_empty;
                assign lvl_empty[L]   = f_empty;
            end

            if (L == LEVELS - 1) begin : g_tail
                assign dst_ready[L] = out_ready;
            end
        end
    endgenerate

    assign out_valid = dst_valid[LEVELS-1];
    assign out_vid   = dst_idx[LEVELS-1];
    assign out_last  = ctl_q.last;

    logic drained;
    always_comb begin
        drained = 1'b1;
        for (int i = 0; i < int'(LEVELS); i++)
            if (dst_valid[i] || !lvl_empty[i]) drained = 1'b0;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.last = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (swap_req || ctl_q.pend) begin
                    ctl_d.st    = ST_LOAD;
                    ctl_d.wbank = ~ctl_q.wbank;
                    ctl_d.pend  = 1'b0;
                end
            end
            ST_LOAD: begin
                ctl_d.st = ST_RUN;
                if (swap_req) ctl_d.pend = 1'b1;
            end
            default: begin
                if (swap_req) ctl_d.pend = 1'b1;
                if (drained) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.last = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_IDLE, wbank: 1'b0, pend: 1'b0, last: 1'b0};
        else     ctl_q <= ctl_d;
    end

    // Observation state for the ordering check.
    logic [VID_W-1:0] prev_vid;
    logic             prev_ok;
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vid <= '0;
            prev_ok  <= 1'b0;
        end else if (ctl_q.st == ST_LOAD) begin
            prev_ok <= 1'b0;
        end else if (out_valid && out_ready) begin
            prev_vid <= out_vid;
            prev_ok  <= 1'b1;
        end
    end

    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && prev_ok) |-> (out_vid > prev_vid));  // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vid)));  // R5
    AST_LAST_ALONE: assert property (@(posedge clk) disable iff (rst)
        out_last |-> !out_valid);  // R6
    AST_LAST_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_last);  // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_IDLE) |-> !out_valid);  // R7

endmodule

// File: tb/tb_hier_active_set.sv
`timescale 1ns/1ps
module tb_hier_active_set;
    localparam int VW = 12;
    localparam int NV = 1 << VW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 1'b0;
    logic [VW-1:0] ins_vid = '0;
    logic swap_req = 1'b0;
    logic out_valid, out_last;
    logic [VW-1:0] out_vid;
    logic out_ready = 1'b1;

    always #2.5 clk = ~clk;

    hier_active_set dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_vid(ins_vid),
        .swap_req(swap_req), .out_valid(out_valid), .out_vid(out_vid),
        .out_ready(out_ready), .out_last(out_last)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Behavioural reference: a set for the next list, a queue for the current.
    bit    nxt [NV];
    int    q[$];
    bit    m_busy = 0, m_pend = 0;
    int    m_got = 0, m_lasts = 0;
    string tag = "R2";
    bit    p_stall = 0;
    int    p_vid = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit acc;
            if (p_stall)
                check(out_valid && int'(out_vid) == p_vid, "R5 stalled output changed",
                      int'(out_vid), p_vid);
            if (out_valid && !m_busy)
                check(1'b0, "R7 ID offered with no list running", int'(out_vid), -1);
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, {tag, " unexpected extra ID"}, int'(out_vid), -1);
                end else begin
                    int e;
                    e = q.pop_front();
                    check(int'(out_vid) == e, {tag, " ID order/content"}, int'(out_vid), e);
                    m_got++;
                end
            end
            if (out_last) begin
                check(m_busy && q.size() == 0 && !out_valid, "R6 end pulse early or stray",
                      q.size(), 0);
                m_busy = 0;
                m_lasts++;
            end
            p_stall = out_valid && !out_ready;
            p_vid   = int'(out_vid);
            acc = !m_busy && (swap_req || m_pend);
            if (!acc && swap_req) m_pend = 1;
            if (ins_valid) nxt[ins_vid] = 1;
            if (acc) begin
                m_pend = 0;
                m_busy = 1;
                q.delete();
                for (int i = 0; i < NV; i++)
                    if (nxt[i]) begin
                        q.push_back(i);
                        nxt[i] = 0;
                    end
            end
        end
    end

    // Consumer ready pattern.
    int rmode = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = (cyc % 4 == 0);
        endcase
    end

    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic put(input int v);
        ins_valid = 1'b1; ins_vid = VW'(v); step(); ins_valid = 1'b0;
    endtask
    task automatic swp();
        swap_req = 1'b1; step(); swap_req = 1'b0;
    endtask
    task automatic put_swp(input int v);
        ins_valid = 1'b1; ins_vid = VW'(v); swap_req = 1'b1; step();
        ins_valid = 1'b0; swap_req = 1'b0;
    endtask
    task automatic wait_done(input string msg);
        int n = 0;
        step();
        while ((m_busy || m_pend) && n < 20000) begin
            step();
            n++;
        end
        check(n < 20000, {msg, " list never finished"}, n, 20000);
        step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base_l;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check(!out_valid && !out_last, "R1 outputs during reset", out_valid, 0);
        end
        @(posedge clk); #1; rst = 1'b0;
        step();
        check(!out_valid && !out_last, "R1 outputs after reset", out_valid, 0);

        // R1 R6: first swap on empty banks
        m_got = 0; base_l = m_lasts;
        swp(); wait_done("R1");
        check(m_got == 0, "R1 IDs from empty bank", m_got, 0);
        check(m_lasts == base_l + 1, "R6 pulse for empty list", m_lasts - base_l, 1);

        // R2 R9: scattered IDs, extremes, duplicate
        tag = "R9"; m_got = 0;
        put(4095); put(0); put(17); put(16); put(17); put(2048); put(255); put(256);
        swp(); wait_done("R9");
        check(m_got == 7, "R2 R9 distinct count with ends of range", m_got, 7);

        // R5: dense group across boundaries, random stalls
        tag = "R5"; rmode = 1; m_got = 0;
        for (int v = 'h12F; v >= 'h11F; v--) put(v);
        put('h130);
        swp(); wait_done("R5");
        check(m_got == 18, "R5 dense group count under stalls", m_got, 18);

        // R4 R7: inserts and a swap while a slow extraction runs
        tag = "R4"; rmode = 2; m_got = 0; base_l = m_lasts;
        for (int i = 0; i < 40; i++) put((i * 97 + 5) % NV);
        swp();
        put(3); put(4000); put(1234);
        swp();
        check(m_busy && m_pend, "R7 swap not held while busy", m_pend, 1);
        wait_done("R4");
        check(m_got == 43, "R4 R7 both lists complete", m_got, 43);
        check(m_lasts == base_l + 2, "R7 two end pulses", m_lasts - base_l, 2);

        // R3: insert on the swap cycle and on the cycle after
        tag = "R3"; rmode = 0; m_got = 0;
        put(5); put_swp(9); put(7);
        wait_done("R3");
        check(m_got == 2, "R3 same-cycle insert in started list", m_got, 2);
        m_got = 0;
        swp(); wait_done("R3");
        check(m_got == 1, "R3 next-cycle insert in later list", m_got, 1);

        // R8: both banks re-read after draining
        tag = "R8"; m_got = 0;
        swp(); wait_done("R8");
        swp(); wait_done("R8");
        check(m_got == 0, "R8 stale IDs after drain", m_got, 0);

        // R2: large pseudo-random list with random stalls
        tag = "R2"; rmode = 1; m_got = 0;
        begin
            bit seen [NV];
            int distinct = 0;
            int s = 12345;
            for (int i = 0; i < 300; i++) begin
                s = (s * 1103515245 + 12345) & 32'h7fffffff;
                if (!seen[(s >> 8) % NV]) distinct++;
                seen[(s >> 8) % NV] = 1;
                put((s >> 8) % NV);
            end
            swp(); wait_done("R2");
            check(m_got == distinct, "R2 random list count", m_got, distinct);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule